// File: doc/BRIEF.md
# Programmable UART Baud Divider

This block produces the oversampling enable for a 16450-class serial port. It divides the reference clock by a 16-bit integer that software loads as two byte registers, a low byte and a high byte. The output is a pulse one reference cycle wide that repeats at sixteen times the serial bit rate. The transmitter uses this pulse to shift bits and the receiver uses it to sample. To get rate B from reference frequency F, software programs the divisor F / (16 × B). For example, 14.7456 MHz at 9600 baud needs a divisor of 96.

The divisor registers have no value that software can rely on after reset. For that reason the block stays silent and reports itself as unprogrammed until both bytes have been written at least once. A divisor of zero is invalid and also keeps the output silent. Each write to either byte restarts the period, so a changed divisor never produces a shortened pulse interval.

Top module: `uart_baud_gen`

## Requirements
- R1: After reset is released, `tick_o` and `programmed_o` are both low.
- R2: `programmed_o` goes high in the cycle after the clock edge that completes writes to both the low byte and the high byte since reset. It stays high until the next reset. A write to only one byte leaves it low.
- R3: While `programmed_o` is low, `tick_o` stays low.
- R4: While the divisor {high byte, low byte} equals 0, `tick_o` stays low.
- R5: With divisor N ≥ 2 and the block programmed, `tick_o` is high for exactly one cycle out of every N cycles.
- R6: With divisor 1 and the block programmed, `tick_o` is high on every cycle.
- R7: A write to either byte on clock edge E restarts the period. `tick_o` is low in the N−1 cycles after E and first goes high in the N-th cycle after E, where N is the new divisor.
- R8: `div_lo_o` and `div_hi_o` show the last byte written to each register from the cycle after the write edge onward. They change at no other time.
- R9: If both write strobes are high on the same edge, `wdata_i` is loaded into both bytes.
- R10: The full 16-bit range works: the high byte weights the divisor by 256, and N = 65535 gives one tick every 65535 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wdata_i | input | 8 | Write data for the divisor bytes |
| wr_lo_i | input | 1 | Write strobe, divisor low byte |
| wr_hi_i | input | 1 | Write strobe, divisor high byte |
| div_lo_o | output | 8 | Readback of the divisor low byte |
| div_hi_o | output | 8 | Readback of the divisor high byte |
| programmed_o | output | 1 | Both divisor bytes have been written since reset |
| tick_o | output | 1 | 16x oversampling enable, one cycle wide |

## Verification
The assertions check the following on every cycle:
- the output is silent while unprogrammed or while the divisor is zero;
- the programmed flag never falls and only rises after a write;
- the readback bytes follow the write strobes;
- the spacing of every pulse equals the divisor, measured from the previous pulse or the last write.

Some behaviours can only be shown by the bench's scenarios:
- a pulse that should come but never appears, which is a pulse gap on a programmed non-zero divisor;
- the full-period restart after a write in mid-period;
- the 65535 extreme;
- a single byte write leaving the block unprogrammed.

// File: rtl/uart_baud_pkg.sv
package uart_baud_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned N_BYTES = 2;
  localparam int unsigned DIV_W = BYTE_W * N_BYTES;
  typedef logic [DIV_W-1:0] div_t;
endpackage

// File: rtl/uart_baud_regs.sv
module uart_baud_regs #(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned N_BYTES = 2,
  localparam int unsigned DIV_W = BYTE_W * N_BYTES
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [BYTE_W-1:0]  wdata_i,
  input  logic [N_BYTES-1:0] wr_i,
  output logic [DIV_W-1:0]   div_o,
  output logic [N_BYTES-1:0] seen_o
);
  // one byte lane per strobe; reset value is not visible to software
  for (genvar g = 0; g < N_BYTES; g++) begin : g_lane
    logic [BYTE_W-1:0] q;
    logic              seen_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        q      <= '0;
        seen_q <= 1'b0;
      end else if (wr_i[g]) begin
        q      <= wdata_i;
        seen_q <= 1'b1;
      end
    end
    assign div_o[g*BYTE_W +: BYTE_W] = q;
    assign seen_o[g] = seen_q;
  end
endmodule

// File: rtl/uart_baud_ctrl.sv
module uart_baud_ctrl #(
  parameter int unsigned N_BYTES = 2,
  parameter int unsigned DIV_W = 16
) (
  input  logic [N_BYTES-1:0] seen_i,
  input  logic [N_BYTES-1:0] wr_i,
  input  logic [DIV_W-1:0]   div_i,
  output logic               programmed_o,
  output logic               run_o,
  output logic               restart_o
);
  always_comb begin
    programmed_o = &seen_i;
    run_o        = programmed_o && (div_i != '0);
    restart_o    = |wr_i;
  end
endmodule

// File: rtl/uart_baud_counter.sv
module uart_baud_counter #(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  input  logic             run_i,
  input  logic             restart_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;
  logic             last;

  assign last   = (cnt_q == div_i - 1'b1);
  assign tick_o = run_i && last;

  // restart on any divisor write so a new period is never truncated
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          cnt_q <= '0;
    else if (restart_i || !run_i || last) cnt_q <= '0;
    else                                  cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/uart_baud_gen.sv
module uart_baud_gen
  import uart_baud_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic              wr_lo_i,
  input  logic              wr_hi_i,
  output logic [BYTE_W-1:0] div_lo_o,
  output logic [BYTE_W-1:0] div_hi_o,
  output logic              programmed_o,
  output logic              tick_o
);
  logic [N_BYTES-1:0] wr;
  logic [N_BYTES-1:0] seen;
  div_t               div;
  logic               run;
  logic               restart;

  assign wr = {wr_hi_i, wr_lo_i};

  uart_baud_regs #(.BYTE_W(BYTE_W), .N_BYTES(N_BYTES)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wdata_i (wdata_i),
    .wr_i    (wr),
    .div_o   (div),
    .seen_o  (seen)
  );

  uart_baud_ctrl #(.N_BYTES(N_BYTES), .DIV_W(DIV_W)) u_ctrl (
    .seen_i       (seen),
    .wr_i         (wr),
    .div_i        (div),
    .programmed_o (programmed_o),
    .run_o        (run),
    .restart_o    (restart)
  );

  uart_baud_counter #(.DIV_W(DIV_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .div_i     (div),
    .run_i     (run),
    .restart_i (restart),
    .tick_o    (tick_o)
  );

  assign div_lo_o = div[BYTE_W-1:0];
  assign div_hi_o = div[DIV_W-1:BYTE_W];
endmodule

// File: rtl/uart_baud_chk.sv
module uart_baud_chk #(
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned DIV_W = 2 * BYTE_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [BYTE_W-1:0] wdata_i,
  input logic              wr_lo_i,
  input logic              wr_hi_i,
  input logic [BYTE_W-1:0] div_lo_o,
  input logic [BYTE_W-1:0] div_hi_o,
  input logic              programmed_o,
  input logic              tick_o
);
  logic [DIV_W-1:0] div;
  logic [DIV_W:0]   gap_q;

  assign div = {div_hi_o, div_lo_o};

  // cycles since the last tick or divisor write, saturating
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           gap_q <= '0;
    else if (wr_lo_i || wr_hi_i || tick_o) gap_q <= '0;
    else if (gap_q != '1)                  gap_q <= gap_q + 1'b1;
  end

  AST_IDLE_UNPROG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !programmed_o |-> !tick_o); // R3
  AST_ZERO_DIV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (div == '0) |-> !tick_o); // R4
  AST_PROG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    programmed_o |=> programmed_o); // R2
  AST_PROG_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!programmed_o && !wr_lo_i && !wr_hi_i) |=> !programmed_o); // R2
  AST_LO_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_lo_i |=> (div_lo_o == $past(wdata_i))); // R8
  AST_HI_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_hi_i |=> (div_hi_o == $past(wdata_i))); // R8
  AST_LO_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_lo_i |=> $stable(div_lo_o)); // R8
  AST_HI_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_hi_i |=> $stable(div_hi_o)); // R8
  AST_DIV_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (programmed_o && div == 1) |-> tick_o); // R6
  AST_TICK_SPACING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |-> (gap_q == {1'b0, div} - 1'b1)); // R5 R7
endmodule

bind uart_baud_gen uart_baud_chk #(.BYTE_W(uart_baud_pkg::BYTE_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .wdata_i      (wdata_i),
  .wr_lo_i      (wr_lo_i),
  .wr_hi_i      (wr_hi_i),
  .div_lo_o     (div_lo_o),
  .div_hi_o     (div_hi_o),
  .programmed_o (programmed_o),
  .tick_o       (tick_o)
);

// File: tb/uart_baud_gen_bench.sv
module uart_baud_gen_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] wdata_i = '0;
  logic       wr_lo_i = 1'b0;
  logic       wr_hi_i = 1'b0;
  logic [7:0] div_lo_o;
  logic [7:0] div_hi_o;
  logic       programmed_o;
  logic       tick_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  // reference model state
  int  m_lo = 0, m_hi = 0;
  bit  m_seen_lo = 0, m_seen_hi = 0;
  int  m_since = 0;
  bit  m_live = 0;
  int  tick_count = 0;

  always #2 clk_i = ~clk_i;

  uart_baud_gen u_uart_baud_gen (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wdata_i      (wdata_i),
    .wr_lo_i      (wr_lo_i),
    .wr_hi_i      (wr_hi_i),
    .div_lo_o     (div_lo_o),
    .div_hi_o     (div_hi_o),
    .programmed_o (programmed_o),
    .tick_o       (tick_o)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  always @(posedge clk_i) begin
    cycles++;
    if (rst_ni) begin
      if (wr_lo_i) begin m_lo = wdata_i; m_seen_lo = 1; end
      if (wr_hi_i) begin m_hi = wdata_i; m_seen_hi = 1; end
      if (wr_lo_i || wr_hi_i) m_since = 0;
      else m_since++;
    end
  end

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk_i) begin
    if (m_live) begin
      int    n;
      bit    prog;
      bit    exp_tick;
      string tag;
      n = m_hi * 256 + m_lo;
      prog = m_seen_lo && m_seen_hi;
      exp_tick = prog && n != 0 && (m_since % (n == 0 ? 1 : n)) == n - 1;
      if (!prog) tag = "R3";
      else if (n == 0) tag = "R4";
      else if (n == 1) tag = "R6";
      else if (n > 255) tag = "R10";
      else tag = "R5";
      check(tick_o == exp_tick, tag, tick_o, exp_tick);
      check(programmed_o == prog, "R2", programmed_o, prog);
      if (m_seen_lo) check(div_lo_o == m_lo, "R8", div_lo_o, m_lo);
      if (m_seen_hi) check(div_hi_o == m_hi, "R8", div_hi_o, m_hi);
      if (tick_o) tick_count++;
    end
  end

  task automatic wr(input bit lo, input bit hi, input logic [7:0] d);
    @(negedge clk_i);
    wdata_i = d; wr_lo_i = lo; wr_hi_i = hi;
    @(negedge clk_i);
    wr_lo_i = 0; wr_hi_i = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  task automatic finish_run();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    int t0;
    int first;
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    check(tick_o == 0, "R1", tick_o, 0);
    check(programmed_o == 0, "R1", programmed_o, 0);
    m_live = 1;
    idle(20);
    // only the low byte: still unprogrammed
    wr(1, 0, 8'd4);
    idle(20);
    check(programmed_o == 0, "R2", programmed_o, 0);
    wr(0, 1, 8'd0);
    // divisor 4: count pulses in 40 cycles
    t0 = tick_count;
    idle(40);
    check(tick_count - t0 == 10, "R5", tick_count - t0, 10);
    // zero divisor
    wr(1, 0, 8'd0);
    t0 = tick_count;
    idle(30);
    check(tick_count - t0 == 0, "R4", tick_count - t0, 0);
    // both strobes together -> 0x0101
    wr(1, 1, 8'h01);
    check(div_lo_o == 8'h01 && div_hi_o == 8'h01, "R9", {div_hi_o, div_lo_o}, 16'h0101);
    idle(600);
    // divisor 1
    wr(0, 1, 8'd0);
    t0 = tick_count;
    idle(12);
    check(tick_count - t0 == 12, "R6", tick_count - t0, 12);
    // divisor 7 with a mid-period rewrite
    wr(1, 0, 8'd7);
    idle(10);
    wr(1, 0, 8'd7);
    // the write's edge is behind us; find the first tick
    first = 0;
    for (int i = 1; i <= 10; i++) begin
      if (tick_o && first == 0) first = i;
      if (i < 10) @(negedge clk_i);
    end
    check(first == 7, "R7", first, 7);
    idle(20);
    // 300 = 0x012C
    wr(0, 1, 8'h01);
    wr(1, 0, 8'h2C);
    t0 = tick_count;
    idle(900);
    check(tick_count - t0 == 3, "R10", tick_count - t0, 3);
    // maximum divisor
    wr(1, 1, 8'hFF);
    t0 = tick_count;
    idle(65536);
    check(tick_count - t0 == 1, "R10", tick_count - t0, 1);
    finish_run();
  end

  initial begin
    #(4 * 199000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 0);
      finish_run();
    end
  end
endmodule